// File: doc/BRIEF.md
# Row-Column Thermometer Cell Selector

This block turns a binary sample into the on/off pattern for a square matrix of unit current cells, 32 by 32 by default. The sample is split into two halves. The upper half drives a row thermometer decoder and the lower half drives a column thermometer decoder. Each matrix cell holds a small gate network that combines its row and column lines into a single "on" decision.

A register in every cell samples that decision on the clock. The register drives a true/complement pair of switch controls, so every switch moves only at a clock edge. The selection is thermometer-like across the whole matrix. Rows below the row index are fully on, the row at the index is filled up to the column index, and rows above it are off. The number of active cells therefore equals the input code, and raising the code by one adds exactly one cell.

Top module: `cellsel_matrix`

## Requirements
- R1: The upper 5 bits of `code` give the row index r and the lower 5 bits give the column index c. Cell (r,c) drives bit r*32+c of `sw_p` and of `sw_n`.
- R2: Cell (r,c) is on when the row half is greater than r, or when the row half equals r and the column half is greater than c. Equivalently, bit i of `sw_p` is 1 exactly when i < code.
- R3: The number of ones in `sw_p` equals the registered code, for every code from 0 to 1023.
- R4: When the code rises by one between consecutive cycles, exactly one more cell turns on and no cell that was on turns off.
- R5: On every cycle outside reset, `sw_n` is the bitwise complement of `sw_p`.
- R6: The outputs reflect the code sampled at the previous rising clock edge. A new code does not change the outputs before that edge.
- R7: A low `rst_n` at a rising edge clears every cell, leaving `sw_p` all zeros and `sw_n` all ones, whatever the code.
- R8: Cell (31,31), bit 1023, never turns on. Code 1023 turns on every other cell.
- R9: Code 0 leaves every cell off.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; all cell registers update on its rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| code | input | 10 | Binary sample; upper half selects the row, lower half the column |
| sw_p | output | 1024 | Registered true switch control per cell, index r*32+c |
| sw_n | output | 1024 | Registered complement switch control per cell |

## Verification
Reset and the loading of a new code can meet at the same clock edge. The bench provokes this in two ways. It holds a large nonzero code on the input while `rst_n` is low, and it releases reset in the same cycle that a fresh code is presented. The first edge must leave every cell cleared. The following edge must show exactly the presented code's pattern, with no stale cells carried over from before the reset. Every result is judged against a pattern computed in the bench as "bit i set when i is below the code".

// File: rtl/cellsel_pkg.sv
// Package: shared sizing for the row-column cell selector.
// Assumes a square matrix whose side is a power of two.
package cellsel_pkg;
    localparam int unsigned HALF_W_DEF = 5;
endpackage

// File: rtl/therm_dec.sv
// Module: therm_dec
// Binary-to-thermometer decoder. Line i is high when the input value is
// greater than i. Line 0 is therefore the OR of the inputs and the top line
// is never set by this definition. Purely combinational.
module therm_dec #(
    parameter int unsigned IN_W = 5,
    localparam int unsigned LINES = 1 << IN_W
) (
    input  logic [IN_W-1:0]  bin,
    output logic [LINES-1:0] lines
);
    genvar i;
    generate
        for (i = 0; i < LINES; i++) begin : g_line
            // compare against the fixed threshold of this line
            assign lines[i] = (bin > IN_W'(i));
        end
    endgenerate

    // decoder output must keep thermometer shape and count the input
    always_comb begin
        if (!$isunknown(bin)) begin
            assert ($countones(lines) == int'(bin))
                else $error("p_therm_count_r2: line count differs from input");
            assert ((lines & ~(lines >> 1) & ~LINES'(1)) == '0 || lines == '0
                    || (lines & (lines + 1'b1)) == '0)
                else $error("p_therm_shape_r2: lines are not a thermometer");
        end
    end
endmodule

// File: rtl/cell_unit.sv
// Module: cell_unit
// One matrix cell. Combines the row-greater, row-equal and column-greater
// lines with OR/NAND gating, then registers the decision into a
// true/complement switch pair. Assumes the row-equal input is one-hot across
// rows, as the top module provides.
module cell_unit (
    input  logic clk,
    input  logic rst_n,
    input  logic row_gt,
    input  logic row_eq,
    input  logic col_gt,
    output logic sw_p,
    output logic sw_n
);
    logic sel_on;

    // on when a full row below, or the active row filled past this column
    assign sel_on = ~(~row_gt & ~(row_eq & col_gt));

    // retime the decision; true and complement sides held in separate flops
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sw_p <= 1'b0;
            sw_n <= 1'b1;
        end else begin
            sw_p <= sel_on;
            sw_n <= ~sel_on;
        end
    end

    // the two switch controls must never agree
    p_pair_compl_r5: assert property (@(posedge clk) disable iff (!rst_n)
        sw_p != sw_n);
endmodule

// File: rtl/cellsel_matrix.sv
// Module: cellsel_matrix (top)
// Splits the code into row and column halves, decodes each to thermometer
// lines, derives a one-hot row-equal vector, and instantiates the square
// matrix of registered cells. The output bit index is row*LINES+column.
// Outputs lag the code by one clock.
module cellsel_matrix #(
    parameter int unsigned HALF_W = cellsel_pkg::HALF_W_DEF,
    localparam int unsigned CODE_W = 2 * HALF_W,
    localparam int unsigned LINES  = 1 << HALF_W,
    localparam int unsigned CELLS  = LINES * LINES
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [CODE_W-1:0] code,
    output logic [CELLS-1:0]  sw_p,
    output logic [CELLS-1:0]  sw_n
);
    logic [HALF_W-1:0] row_bin;
    logic [HALF_W-1:0] col_bin;
    logic [LINES-1:0]  row_gt;
    logic [LINES-1:0]  col_gt;
    logic [LINES-1:0]  row_eq;

    // split the sample into its row and column halves
    assign row_bin = code[CODE_W-1:HALF_W];
    assign col_bin = code[HALF_W-1:0];

    therm_dec #(.IN_W(HALF_W)) u_row_dec (.bin(row_bin), .lines(row_gt));
    therm_dec #(.IN_W(HALF_W)) u_col_dec (.bin(col_bin), .lines(col_gt));

    genvar r, c;
    generate
        for (r = 0; r < LINES; r++) begin : g_row
            // row r is the active row when line r-1 is high and line r is low
            if (r == 0) begin : g_first
                assign row_eq[r] = ~row_gt[r];
            end else begin : g_rest
                assign row_eq[r] = row_gt[r-1] & ~row_gt[r];
            end
            for (c = 0; c < LINES; c++) begin : g_col
                cell_unit u_cell (
                    .clk    (clk),
                    .rst_n  (rst_n),
                    .row_gt (row_gt[r]),
                    .row_eq (row_eq[r]),
                    .col_gt (col_gt[c]),
                    .sw_p   (sw_p[r*LINES+c]),
                    .sw_n   (sw_n[r*LINES+c])
                );
            end
        end
    endgenerate

    // exactly one row is the active row
    p_row_onehot_r1: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(row_eq) == 1);

    // active cell count tracks the code sampled one edge earlier
    p_count_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> ($countones(sw_p) == int'($past(code))));

    // after a reset edge every cell is off
    p_reset_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(rst_n) |-> (sw_p == '0));

    // a unit step in the code adds one cell and drops none
    p_step_mono_r4: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(code) != '1 && code == $past(code) + 1'b1)
        |=> (($past(sw_p) & ~sw_p) == '0)
            && ($countones(sw_p) == $countones($past(sw_p)) + 1));

    // the last cell of the matrix never turns on
    p_last_off_r8: assert property (@(posedge clk) disable iff (!rst_n)
        sw_p[CELLS-1] == 1'b0);
endmodule

// File: tb/tb_cellsel_matrix.sv
module tb_cellsel_matrix;
    localparam int CELLS = 1024;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic [9:0]        code = '0;
    logic [CELLS-1:0]  sw_p;
    logic [CELLS-1:0]  sw_n;

    int n_chk = 0;
    int n_bad = 0;
    bit finished = 1'b0;

    cellsel_matrix dut (.clk(clk), .rst_n(rst_n), .code(code),
                        .sw_p(sw_p), .sw_n(sw_n));

    always #5 clk = ~clk;

    function automatic logic [CELLS-1:0] pattern(input int v);
        logic [CELLS-1:0] p;
        for (int i = 0; i < CELLS; i++) p[i] = (i < v);
        return p;
    endfunction

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic check_vec(input string req, input int v);
        logic [CELLS-1:0] e;
        e = pattern(v);
        check(sw_p == e, req, $countones(sw_p), v);
        check(sw_n == ~e, {req, " R5"}, $countones(sw_n), CELLS - v);
    endtask

    // drive at a falling edge, judge after the next rising edge
    task automatic apply(input int v);
        @(negedge clk) code = 10'(v);
        @(negedge clk);
    endtask

    task automatic t_reset;
        // R7: reset while a large code is present
        rst_n = 1'b0;
        code = 10'd700;
        @(negedge clk);
        @(negedge clk);
        check_vec("R7", 0);
    endtask

    task automatic t_release_with_code;
        // R7/R6: reset release coincides with a new code
        @(negedge clk) begin rst_n = 1'b1; code = 10'd613; end
        #1 check(sw_p == '0, "R6 no early change", $countones(sw_p), 0);
        @(negedge clk);
        check_vec("R6", 613);
    endtask

    task automatic t_corners;
        int vals[9] = '{0, 1, 31, 32, 33, 511, 512, 1022, 1023};
        foreach (vals[k]) begin
            apply(vals[k]);
            check_vec("R2", vals[k]);
        end
        // R9: code 0
        apply(0);
        check(sw_p == '0, "R9", $countones(sw_p), 0);
        // R8: full scale leaves only the last cell off
        apply(1023);
        check(sw_p[CELLS-1] == 1'b0, "R8", int'(sw_p[CELLS-1]), 0);
        check($countones(sw_p) == 1023, "R8", $countones(sw_p), 1023);
    endtask

    task automatic t_index;
        // R1: row 1 column 3 -> cells 0..34 on, 35 off
        apply({5'd1, 5'd3});
        check(sw_p[34] == 1'b1, "R1 bit34", int'(sw_p[34]), 1);
        check(sw_p[35] == 1'b0, "R1 bit35", int'(sw_p[35]), 0);
        check(sw_p[31] == 1'b1, "R1 bit31", int'(sw_p[31]), 1);
    endtask

    task automatic t_ramp;
        logic [CELLS-1:0] prev;
        apply(0);
        prev = sw_p;
        for (int v = 1; v < 1024; v++) begin
            apply(v);
            check($countones(sw_p) == v, "R3", $countones(sw_p), v);
            check((prev & ~sw_p) == '0, "R4 drop", $countones(prev & ~sw_p), 0);
            check($countones(sw_p & ~prev) == 1, "R4 add", $countones(sw_p & ~prev), 1);
            prev = sw_p;
        end
    endtask

    task automatic t_scatter;
        int v = 17;
        for (int k = 0; k < 40; k++) begin
            v = (v * 373 + 101) % 1024;
            apply(v);
            check_vec("R2", v);
        end
    endtask

    task automatic t_mid_reset;
        // R7: reset from a full state
        apply(1000);
        @(negedge clk) rst_n = 1'b0;
        @(negedge clk);
        check_vec("R7 mid", 0);
        @(negedge clk) rst_n = 1'b1;
        @(negedge clk);
        check_vec("R6 after", 1000);
    endtask

    initial begin
        t_reset();
        t_release_with_code();
        t_corners();
        t_index();
        t_ramp();
        t_scatter();
        t_mid_reset();
        finished = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        #(150000 * 10);
        if (!finished) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end
endmodule